// File: doc/BRIEF.md
# Memory-Mapped Byte Serial Port

This block is a bus-slave peripheral that sits between a processor's byte-wide load/store bus and a byte-stream serial link. Two synchronous FIFOs decouple the two sides: incoming serial bytes queue in a receive FIFO, and bytes stored by the processor queue in a transmit FIFO until the link accepts them. Five byte registers in an eight-byte window at a parameterised base address give software a receive-ready flag, the receive head byte, a transmit-space flag, a dequeue strobe and a transmit data register.

Reading the received byte does not consume it. Software first tests the ready flag, then loads the head byte as often as it likes, and then stores any value to the dequeue address to drop that byte. The serial side is a plain byte handshake. Received bytes that arrive while the receive FIFO is full are discarded, and a sticky overflow output records the loss until reset.

Top module: `serial_mmio_port`

## Requirements
- R1: A load from offset 0 returns bit 0 = 1 when the receive FIFO holds at least one byte, else 0; bits 7:1 read 0.
- R2: A load from offset 1 returns the receive FIFO head byte without removing it, so repeated loads return the same byte; it reads 0 when the receive FIFO is empty.
- R3: A load from offset 2 returns bit 0 = 1 when the transmit FIFO holds fewer than DEPTH bytes, else 0; bits 7:1 read 0.
- R4: A store of any value to offset 3 removes exactly one receive FIFO entry at the clock edge; a store there while the receive FIFO is empty is ignored.
- R5: A store to offset 4 appends bus_wdata to the transmit FIFO; a store there while the transmit FIFO is full is ignored and the stored contents are unchanged.
- R6: tx_valid is 1 whenever the transmit FIFO is non-empty, tx_data is its head byte in store order, and the head is removed on a clock edge where tx_valid and tx_ready are both 1.
- R7: A byte on rx_data with rx_valid = 1 is appended to the receive FIFO when it is not full; when it is full the byte is dropped and rx_overflow becomes 1 and stays 1 until reset.
- R8: Stores to offsets 0, 1, 2, 5, 6, 7, loads from offsets 3 to 7, and any access outside the window change no state; bus_rdata is 0 for every cycle that is not a load from offset 0, 1 or 2 in the window.
- R9: After reset both FIFOs are empty, rx_overflow is 0 and tx_valid is 0.
- R10: Each FIFO holds exactly DEPTH bytes (default 16); a DEPTH that is not a power of two is supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Store data |
| bus_rdata | output | 8 | Load data, combinational in the same cycle |
| rx_valid | input | 1 | Serial side offers a received byte |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Serial side accepts the transmit byte |
| tx_data | output | 8 | Transmit head byte |
| rx_overflow | output | 1 | Sticky flag: a received byte was dropped |

## Verification
A wrong FIFO pointer or count shows at the ports within one cycle: the ready flags at offsets 0 and 2 flip at the wrong occupancy, the head byte at offset 1 or on tx_data repeats or skips a byte, or rx_overflow rises early or late. Because the reference model is compared on every clock, a corrupted pointer after an ignored pop or push is caught at the very next load or at the first byte leaving the transmit side. A decode fault appears as a nonzero bus_rdata on a non-load cycle or as a queue length changed by a stray access.

// File: rtl/smp_pkg.sv
package smp_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned WIN_W  = 3;

   typedef enum logic [WIN_W-1:0] {
      OFS_RX_STAT = 3'd0,
      OFS_RX_DATA = 3'd1,
      OFS_TX_STAT = 3'd2,
      OFS_RX_POP  = 3'd3,
      OFS_TX_PUSH = 3'd4
   } smp_ofs_e;

   typedef struct packed {
      logic ld_rx_stat;
      logic ld_rx_data;
      logic ld_tx_stat;
      logic st_rx_pop;
      logic st_tx_push;
   } smp_strobe_t;

endpackage

// File: rtl/smp_fifo.sv
module smp_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);

   localparam int unsigned PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW     = $clog2(DEPTH + 1);
   localparam bit          IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("smp_fifo: DEPTH must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("smp_fifo: W must be at least 1");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   generate
      if (IS_POW2) begin : g_wrap_free
         assign rd_nxt = rd_ptr + 1'b1;
         assign wr_nxt = wr_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   assign dout = empty ? '0 : mem[rd_ptr];

endmodule

// File: rtl/smp_decode.sv
module smp_decode
   import smp_pkg::*;
#(
   parameter int unsigned    ADDR_W = 32,
   parameter logic [ADDR_W-1:0] BASE = 32'h8000_0000
) (
   input  logic              sel,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   output smp_strobe_t       stb
);

   localparam int unsigned TAG_W = ADDR_W - WIN_W;
   localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1:WIN_W];

   generate
      if (ADDR_W <= WIN_W) begin : g_bad_addr
         $error("smp_decode: ADDR_W too small for the register window");
      end
   endgenerate

   logic             hit;
   logic [WIN_W-1:0] ofs;

   assign hit = sel && (addr[ADDR_W-1:WIN_W] == BASE_TAG);
   assign ofs = addr[WIN_W-1:0];

   always_comb begin
      stb = '0;
      if (hit) begin
         if (!we) begin
            stb.ld_rx_stat = (ofs == OFS_RX_STAT);
            stb.ld_rx_data = (ofs == OFS_RX_DATA);
            stb.ld_tx_stat = (ofs == OFS_TX_STAT);
         end else begin
            stb.st_rx_pop  = (ofs == OFS_RX_POP);
            stb.st_tx_push = (ofs == OFS_TX_PUSH);
         end
      end
   end

endmodule

// File: rtl/serial_mmio_port.sv
module serial_mmio_port
   import smp_pkg::*;
#(
   parameter int unsigned       ADDR_W = 32,
   parameter logic [ADDR_W-1:0] BASE   = 32'h8000_0000,
   parameter int unsigned       DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [7:0]        tx_data,
   output logic              rx_overflow
);

   smp_strobe_t stb;
   logic [7:0]  rx_head, tx_head;
   logic        rx_empty, rx_full, tx_empty, tx_full;
   logic        tx_take;

   smp_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
      .sel  (bus_sel),
      .we   (bus_we),
      .addr (bus_addr),
      .stb  (stb)
   );

   smp_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_valid),
      .din   (rx_data),
      .pop   (stb.st_rx_pop),
      .dout  (rx_head),
      .empty (rx_empty),
      .full  (rx_full)
   );

   assign tx_take = tx_valid && tx_ready;

   smp_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (stb.st_tx_push),
      .din   (bus_wdata),
      .pop   (tx_take),
      .dout  (tx_head),
      .empty (tx_empty),
      .full  (tx_full)
   );

   assign tx_valid = !tx_empty;
   assign tx_data  = tx_head;

   always_ff @(posedge clk) begin
      if (!rst_n)                  rx_overflow <= 1'b0;
      else if (rx_valid && rx_full) rx_overflow <= 1'b1;
   end

   always_comb begin
      unique case (1'b1)
         stb.ld_rx_stat: bus_rdata = {7'd0, !rx_empty};
         stb.ld_rx_data: bus_rdata = rx_head;
         stb.ld_tx_stat: bus_rdata = {7'd0, !tx_full};
         default:        bus_rdata = 8'd0;
      endcase
   end

endmodule

// File: rtl/smp_chk.sv
module smp_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [7:0]        bus_rdata,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic [7:0]        tx_data,
   input logic              rx_overflow,
   input logic              rx_valid,
   input logic              rx_empty,
   input logic              tx_full,
   input logic              st_rx_pop,
   input logic              st_tx_push,
   input logic              ld_rx_stat,
   input logic              ld_rx_data
);

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overflow |=> rx_overflow);

   // R6
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

   // R8
   idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_we) |-> (bus_rdata == 8'd0));

   // R1
   rx_stat_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_rx_stat |-> (bus_rdata[7:1] == 7'd0 && bus_rdata[0] == !rx_empty));

   // R4
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_empty && st_rx_pop && !rx_valid) |=> rx_empty);

   // R5
   full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_full && st_tx_push && !tx_ready) |=> tx_full);

   // R2
   rx_head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_rx_data && !st_rx_pop && !rx_empty) |=> !rx_empty);

endmodule

bind serial_mmio_port smp_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_sel     (bus_sel),
   .bus_we      (bus_we),
   .bus_rdata   (bus_rdata),
   .tx_valid    (tx_valid),
   .tx_ready    (tx_ready),
   .tx_data     (tx_data),
   .rx_overflow (rx_overflow),
   .rx_valid    (rx_valid),
   .rx_empty    (rx_empty),
   .tx_full     (tx_full),
   .st_rx_pop   (stb.st_rx_pop),
   .st_tx_push  (stb.st_tx_push),
   .ld_rx_stat  (stb.ld_rx_stat),
   .ld_rx_data  (stb.ld_rx_data)
);

// File: tb/serial_mmio_port_tb.sv
module serial_mmio_port_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int D          = 16;
   localparam logic [31:0] BASE = 32'h8000_0000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_sel, bus_we;
   logic [31:0] bus_addr;
   logic [7:0]  bus_wdata, bus_rdata;
   logic        rx_valid, tx_valid, tx_ready, rx_overflow;
   logic [7:0]  rx_data, tx_data;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   logic [7:0] rxq[$];
   logic [7:0] txq[$];
   bit         m_ovf;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_mmio_port #(.ADDR_W(32), .BASE(BASE), .DEPTH(D)) dut_i (
      .clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
      .rx_valid, .rx_data, .tx_valid, .tx_ready, .tx_data, .rx_overflow
   );

   function automatic logic [7:0] exp_rdata();
      if (!(bus_sel && !bus_we) || bus_addr[31:3] != BASE[31:3]) return 8'd0;
      case (bus_addr[2:0])
         3'd0:    return {7'd0, rxq.size() > 0};
         3'd1:    return (rxq.size() > 0) ? rxq[0] : 8'd0;
         3'd2:    return {7'd0, txq.size() < D};
         default: return 8'd0;
      endcase
   endfunction

   task automatic cmp(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   // one cycle: drive at negedge, compare, then advance the model at posedge
   task automatic step(input string req, input logic sel, input logic we,
                       input logic [31:0] a, input logic [7:0] wd,
                       input logic rv, input logic [7:0] rd, input logic tr);
      bit pop_ok, push_ok, drop, take, hit;
      bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd;
      rx_valid = rv; rx_data = rd; tx_ready = tr;
      #1;
      cmp(req, "rdata", bus_rdata, exp_rdata());
      cmp(req, "tx_valid", {7'd0, tx_valid}, {7'd0, txq.size() > 0});
      cmp(req, "tx_data", tx_data, (txq.size() > 0) ? txq[0] : 8'd0);
      cmp(req, "rx_overflow", {7'd0, rx_overflow}, {7'd0, m_ovf});
      hit     = sel && we && (a[31:3] == BASE[31:3]);
      pop_ok  = hit && a[2:0] == 3'd3 && rxq.size() > 0;
      push_ok = hit && a[2:0] == 3'd4 && txq.size() < D;
      drop    = rv && rxq.size() == D;
      take    = tr && txq.size() > 0;
      @(posedge clk);
      if (pop_ok) void'(rxq.pop_front());
      if (rv && !drop) rxq.push_back(rd);
      if (drop) m_ovf = 1'b1;
      if (take) void'(txq.pop_front());
      if (push_ok) txq.push_back(wd);
      @(negedge clk);
   endtask

   task automatic ld(input string req, input logic [2:0] o);
      step(req, 1'b1, 1'b0, BASE + 32'(o), 8'h00, 1'b0, 8'h00, 1'b0);
   endtask
   task automatic st(input string req, input logic [2:0] o, input logic [7:0] v);
      step(req, 1'b1, 1'b1, BASE + 32'(o), v, 1'b0, 8'h00, 1'b0);
   endtask
   task automatic rx(input string req, input logic [7:0] v);
      step(req, 1'b0, 1'b0, 32'h0, 8'h00, 1'b1, v, 1'b0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
      rx_valid = 0; rx_data = 0; tx_ready = 0; m_ovf = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state, R1 and R3 flags
      ld("R9", 3'd0);
      ld("R3", 3'd2);
      ld("R2", 3'd1);
      // R7 receive, R2 non-destructive reads
      rx("R7", 8'hA5);
      rx("R7", 8'h3C);
      ld("R1", 3'd0);
      ld("R2", 3'd1);
      ld("R2", 3'd1);
      ld("R2", 3'd1);
      // R8 stores to read-only offsets and loads from write-only ones
      st("R8", 3'd1, 8'hFF);
      st("R8", 3'd0, 8'hFF);
      ld("R8", 3'd3);
      ld("R8", 3'd4);
      ld("R8", 3'd6);
      step("R8", 1'b1, 1'b1, 32'h4000_0003, 8'h11, 1'b0, 8'h0, 1'b0);
      step("R8", 1'b1, 1'b0, 32'h8000_0009, 8'h00, 1'b0, 8'h0, 1'b0);
      ld("R2", 3'd1);
      // R4 pop
      st("R4", 3'd3, 8'h77);
      ld("R4", 3'd1);
      st("R4", 3'd3, 8'h00);
      ld("R4", 3'd0);
      st("R4", 3'd3, 8'h00);
      st("R4", 3'd3, 8'h00);
      rx("R4", 8'h5E);
      ld("R4", 3'd1);
      st("R4", 3'd3, 8'h00);
      // R10 fill receive FIFO, R7 overflow
      for (int i = 0; i < D; i++) rx("R10", 8'(i + 8'h40));
      ld("R1", 3'd0);
      rx("R7", 8'hEE);
      rx("R7", 8'hEF);
      // simultaneous receive and pop while full
      step("R7", 1'b1, 1'b1, BASE + 32'd3, 8'h0, 1'b1, 8'h99, 1'b0);
      for (int i = 0; i < D + 1; i++) begin
         ld("R2", 3'd1);
         st("R4", 3'd3, 8'h00);
      end
      ld("R1", 3'd0);
      // R5 transmit push, R3 full flag, R6 drain
      for (int i = 0; i < D + 2; i++) st("R5", 3'd4, 8'(8'hC0 + i));
      ld("R3", 3'd2);
      step("R6", 1'b0, 1'b0, 32'h0, 8'h0, 1'b0, 8'h0, 1'b1);
      ld("R3", 3'd2);
      step("R6", 1'b1, 1'b1, BASE + 32'd4, 8'h5A, 1'b0, 8'h0, 1'b1);
      for (int i = 0; i < D + 2; i++)
         step("R6", 1'b0, 1'b0, 32'h0, 8'h0, 1'b0, 8'h0, 1'b1);
      // R10 interleaved traffic
      for (int i = 0; i < 40; i++)
         step("R10", 1'b1, 1'b1, BASE + 32'(3 + (i % 2)), 8'(i * 7),
              (i % 3) != 0, 8'(i * 13), (i % 4) == 0);
      // R9 reset again clears overflow and queues
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rxq.delete(); txq.delete(); m_ovf = 0;
      ld("R9", 3'd0);
      ld("R9", 3'd2);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule